// File: doc/BRIEF.md
# Message-signalled interrupt capability with per-vector masking

This block holds the register set of a message-signalled interrupt capability and turns per-vector interrupt requests from device logic into memory-write messages. Software programs it through a dword-addressed configuration port with byte enables. The registers are a control word, a message address (32-bit, or 64-bit when a parameter selects it), a 16-bit message data value, and, when the masking option is built in, a per-vector mask and a pending register. Each message leaves through a valid/ready handshake as a 64-bit address and a 32-bit data word.

When several vectors are enabled, the vector number replaces the low bits of the data value. A request on a masked vector is not sent. Its pending bit is set instead. After a configuration write that lands inside the register set while the capability is enabled, the block does three things in order:
- It clamps an oversized vector-count field.
- It drops pending bits that lie outside the enabled range.
- It sends the unmasked pending vectors, lowest number first.

While the capability is enabled, the legacy level interrupt output is held low.

Top module: `msi_cap`

## Requirements
- R1: The control word sits in bits 31:16 of dword 0, and bits 15:0 of dword 0 read zero. Its fields are:
  - bit 0: enable, writable.
  - bits 3:1: capable, read-only, equal to log2(NVEC).
  - bits 6:4: enabled vectors (log2 of the count), writable.
  - bit 7: 64-bit option, read-only.
  - bit 8: masking option, read-only.
  - All other bits read zero.
  Each byte is written only when its byte enable is set.
- R2: Dword 1 is the low address, and its bits 1:0 always read zero. With the 64-bit option, dword 2 is the writable high address and dword 3 holds the data. Without it, the data is at dword 2. The data occupies bits 15:0, all writable, with bits 31:16 reading zero.
- R3: With masking, the mask sits at the dword after the data and the pending register at the one after that. Only mask bits 0 to NVEC-1 are writable, and higher bits read zero. The pending register is read-only.
- R4: A message carries the address {high, low} with bits 1:0 zero, and a data word whose bits 31:16 are zero. When the enabled count 2^Q is greater than one, the low Q data bits are replaced by the vector number.
- R5: A request on a masked vector produces no message and sets that vector's pending bit.
- R6: On a write inside the register set that leaves enable set, an enabled-vector field above the capable field is clamped to the capable value. While enable is clear, the field keeps what was written.
- R7: On a write inside the register set that leaves enable set, pending bits at or above the enabled count are cleared.
- R8: After such a write, each pending vector that is unmasked is cleared and sent, in ascending vector order. A write outside the register set has no effect.
- R9: While enable is set, the legacy interrupt output is low. Otherwise it follows the legacy request input.
- R10: Reset clears enable, the enabled-vector field, the addresses, the data, the mask and the pending bits. The read-only fields keep their values.
- R11: A request that arrives while enable is clear is dropped and leaves no pending bit. A request on a vector at or above the enabled count is also dropped.
- R12: Only one message is outstanding at a time. While valid is high and ready is low, the message stays stable and no request is lost. Queued vectors leave in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Dword index within the register set |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| irq_req | input | NVEC | Per-vector interrupt request pulses |
| intx_req | input | 1 | Legacy level interrupt request |
| intx_out | output | 1 | Legacy interrupt output |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted by the consumer |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Messages are requested under several enabled-vector counts (one, two and four). This separates a correct merge of the vector number into the data from a fixed-width merge.

Masked and unmasked vectors are requested together in one cycle. This shows that only the unmasked vectors go out and the masked ones are recorded as pending.

Unmasking writes that leave several vectors pending check that the replay runs in ascending order. A write to an index outside the register set checks that no replay starts.

A stalled consumer, with requests landing both before and during the stall, shows whether requests are dropped or reordered while a message waits.

// File: rtl/msi_cap.sv
module msi_cap #(
  parameter int NVEC    = 4,
  parameter bit ADDR64  = 1'b1,
  parameter bit MASKCAP = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_addr,
  input  logic [3:0]      cfg_be,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic [NVEC-1:0] irq_req,
  input  logic            intx_req,
  output logic            intx_out,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [63:0]     msg_addr,
  output logic [31:0]     msg_data
);
  localparam int LOGN     = $clog2(NVEC);
  localparam logic [2:0] CAP = 3'(LOGN);
  localparam int IDX_DATA = ADDR64 ? 3 : 2;
  localparam int IDX_MASK = IDX_DATA + 1;
  localparam int IDX_PEND = IDX_DATA + 2;
  localparam int NDW      = MASKCAP ? IDX_DATA + 3 : IDX_DATA + 1;

  logic            en, arm;
  logic [2:0]      qsize;
  logic [29:0]     addr_lo;
  logic [31:0]     addr_hi;
  logic [15:0]     data;
  logic [NVEC-1:0] mask, pend, want;

  logic            hit, en_n, arm_n, issue;
  logic [2:0]      qw, qsize_n;
  logic [NVEC-1:0] mask_n, pend_n, want_n, ok_cur, ok_new, cand;
  logic [4:0]      sel;
  logic [15:0]     low_m;
  logic [31:0]     merged, cur, ctrl;

  function automatic logic [31:0] bmerge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    for (int b = 0; b < 4; b++)
      if (be[b]) o[8*b +: 8] = n[8*b +: 8];
    return o;
  endfunction

  assign ctrl     = {7'd0, MASKCAP, ADDR64, qsize, CAP, en};
  assign intx_out = intx_req & ~en;
  assign low_m    = 16'((32'd1 << qsize) - 1);

  always_comb begin
    case (32'(cfg_addr))
      0:        cur = {ctrl[15:0], 16'd0};
      1:        cur = {addr_lo, 2'b00};
      2:        cur = ADDR64 ? addr_hi : {16'd0, data};
      IDX_DATA: cur = {16'd0, data};
      IDX_MASK: cur = MASKCAP ? 32'(mask) : 32'd0;
      IDX_PEND: cur = MASKCAP ? 32'(pend) : 32'd0;
      default:  cur = 32'd0;
    endcase
  end
  assign cfg_rdata = cur;
  assign merged    = bmerge(cur, cfg_wdata, cfg_be);
  assign hit       = cfg_wr && (32'(cfg_addr) < NDW);

  always_comb begin
    en_n    = (hit && cfg_addr == 3'd0 && cfg_be[2]) ? cfg_wdata[16] : en;
    qw      = (hit && cfg_addr == 3'd0 && cfg_be[2]) ? cfg_wdata[22:20] : qsize;
    qsize_n = (hit && en_n && qw > CAP) ? CAP : qw;
    mask_n  = (MASKCAP && hit && 32'(cfg_addr) == IDX_MASK) ? merged[NVEC-1:0] : mask;
    for (int v = 0; v < NVEC; v++) begin
      ok_cur[v] = (32'(v) >> qsize) == 0;
      ok_new[v] = (32'(v) >> qsize_n) == 0;
    end
    cand = want | (arm ? (pend & ~mask) : '0);
    sel  = 5'd0;
    for (int v = NVEC - 1; v >= 0; v--)
      if (cand[v]) sel = 5'(v);
    issue  = en && (!msg_valid || msg_ready) && |cand;
    pend_n = pend;
    want_n = want;
    if (issue) begin
      if (want[sel]) want_n[sel] = 1'b0;
      else           pend_n[sel] = 1'b0;
    end
    for (int v = 0; v < NVEC; v++)
      if (irq_req[v] && en && ok_cur[v]) begin
        if (MASKCAP && mask[v]) pend_n[v] = 1'b1;
        else                    want_n[v] = 1'b1;
      end
    if (hit && en_n) begin
      pend_n = pend_n & ok_new;
      want_n = want_n & ok_new;
    end
    if (!en_n)    want_n = '0;
    if (!MASKCAP) pend_n = '0;
    arm_n = (hit && en_n) ? 1'b1 : (arm && en_n && |(pend & ~mask));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; qsize <= 3'd0; addr_lo <= '0; addr_hi <= '0; data <= '0;
      mask <= '0; pend <= '0; want <= '0; arm <= 1'b0;
      msg_valid <= 1'b0; msg_addr <= '0; msg_data <= '0;
    end else begin
      en <= en_n; qsize <= qsize_n; mask <= mask_n; pend <= pend_n;
      want <= want_n; arm <= arm_n;
      if (hit && cfg_addr == 3'd1) addr_lo <= merged[31:2];
      if (hit && ADDR64 && cfg_addr == 3'd2) addr_hi <= merged;
      if (hit && 32'(cfg_addr) == IDX_DATA) data <= merged[15:0];
      if (issue) begin
        msg_valid <= 1'b1;
        msg_addr  <= {ADDR64 ? addr_hi : 32'd0, addr_lo, 2'b00};
        msg_data  <= {16'd0, (data & ~low_m) | (16'(sel) & low_m)};
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end

  a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  a_r6_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> qsize <= CAP);

  a_r11_send_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(en));

  a_r7_pend_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (pend & ~ok_cur) == '0);
endmodule

// File: tb/tb_msi_cap.sv
module tb_msi_cap;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [3:0] cfg_be = 4'hF;
  logic [31:0] cfg_wdata = 32'd0, cfg_rdata;
  logic [3:0] irq_req = 4'd0;
  logic intx_req = 1'b0, intx_out;
  logic msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int checks = 0, errors = 0, m_cnt = 0;
  logic [31:0] m_data [0:63];
  logic [63:0] m_addr [0:63];

  always #2 clk = ~clk;

  msi_cap dut (.*);

  always @(posedge clk)
    if (rst_n && msg_valid && msg_ready) begin
      m_data[m_cnt] = msg_data;
      m_addr[m_cnt] = msg_addr;
      m_cnt++;
    end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 3'(a); cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'hF;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = 3'(a);
    #1 d = cfg_rdata;
  endtask

  task automatic pulse(logic [3:0] m);
    @(negedge clk); irq_req = m;
    @(negedge clk); irq_req = 4'd0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    logic [31:0] d;
    rd(0, d); chk("R10 ctrl after reset", d, 32'h0184_0000);
    rd(1, d); chk("R10 addr lo", d, 0);
    rd(3, d); chk("R10 data", d, 0);
    rd(4, d); chk("R10 mask", d, 0);
    rd(5, d); chk("R10 pending", d, 0);
    chk("R10 no message", msg_valid, 0);
    intx_req = 1'b1; #1;
    chk("R9 intx passes while disabled", intx_out, 1);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    wr(0, 32'h0070_0000);
    rd(0, d); chk("R1 R6 no clamp while disabled", d, 32'h01F4_0000);
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R1 R6 only enable/qsize written, clamped", d, 32'h01A5_0000);
    chk("R9 intx low while enabled", intx_out, 0);
    wr(0, 32'h0000_0000, 4'b1011);
    rd(0, d); chk("R1 byte enable respected", d, 32'h01A5_0000);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R2 addr lo bits 1:0 zero", d, 32'hFFFF_FFFC);
    wr(1, 32'h1122_3344); wr(1, 32'hFFFF_FF77, 4'b0001);
    rd(1, d); chk("R2 addr lo byte write", d, 32'h1122_3374);
    wr(2, 32'h1234_5678); rd(2, d); chk("R2 addr hi", d, 32'h1234_5678);
    wr(3, 32'hFFFF_ABCD); rd(3, d); chk("R2 data 16 bits", d, 32'h0000_ABCD);
    wr(4, 32'hFFFF_FFFF); rd(4, d); chk("R3 mask width", d, 32'h0000_000F);
    wr(5, 32'hFFFF_FFFF); rd(5, d); chk("R3 pending read-only", d, 0);
    wr(4, 0);
  endtask

  task automatic t_message;
    int b;
    wr(1, 32'hFEE0_0000); wr(2, 32'h0000_0001);
    wr(0, 32'h0021_0000, 4'b0100);
    b = m_cnt; pulse(4'b0100); idle(5);
    chk("R4 count", m_cnt - b, 1);
    chk("R4 addr", m_addr[b], 64'h1_FEE0_0000);
    chk("R4 data v2 q2", m_data[b], 32'h0000_ABCE);
    wr(0, 32'h0011_0000, 4'b0100);
    b = m_cnt; pulse(4'b0001); idle(5);
    chk("R4 data v0 q1", m_data[b], 32'h0000_ABCC);
    wr(0, 32'h0001_0000, 4'b0100);
    b = m_cnt; pulse(4'b0010); pulse(4'b0001); idle(5);
    chk("R11 v1 dropped at q0", m_cnt - b, 1);
    chk("R4 data unchanged q0", m_data[b], 32'h0000_ABCD);
  endtask

  task automatic t_mask_replay;
    logic [31:0] d; int b;
    wr(0, 32'h0021_0000, 4'b0100);
    wr(4, 32'h0000_000A);
    b = m_cnt; pulse(4'b1011); idle(5);
    chk("R5 only unmasked sent", m_cnt - b, 1);
    chk("R5 v0 data", m_data[b], 32'h0000_ABCC);
    rd(5, d); chk("R5 pending set", d, 32'h0000_000A);
    b = m_cnt; wr(4, 0); idle(6);
    chk("R8 replay count", m_cnt - b, 2);
    chk("R8 first v1", m_data[b], 32'h0000_ABCD);
    chk("R8 then v3", m_data[b+1], 32'h0000_ABCF);
    rd(5, d); chk("R8 pending cleared", d, 0);
    wr(4, 32'hF); pulse(4'b1100);
    rd(5, d); chk("R5 pending v2 v3", d, 32'h0000_000C);
    wr(0, 32'h0011_0000, 4'b0100);
    rd(5, d); chk("R7 out-of-range pending cleared", d, 0);
    pulse(4'b0010); pulse(4'b0100);
    rd(5, d); chk("R11 R5 only v1 pending", d, 32'h0000_0002);
    b = m_cnt; wr(6, 0); idle(4);
    rd(4, d); chk("R8 outside write no effect on mask", d, 32'hF);
    chk("R8 outside write no replay", m_cnt - b, 0);
    wr(4, 0); idle(5);
    chk("R8 replay v1", m_cnt - b, 1);
    chk("R8 replay v1 data", m_data[b], 32'h0000_ABCD);
  endtask

  task automatic t_stall;
    int b;
    wr(0, 32'h0021_0000, 4'b0100);
    msg_ready = 1'b0; b = m_cnt;
    @(negedge clk); irq_req = 4'b0101;
    @(negedge clk); irq_req = 4'b0010;
    @(negedge clk); irq_req = 4'b0000;
    idle(4);
    chk("R12 valid held", msg_valid, 1);
    chk("R12 first is v0", msg_data, 32'h0000_ABCC);
    idle(3);
    chk("R12 stable while stalled", msg_data, 32'h0000_ABCC);
    msg_ready = 1'b1; idle(6);
    chk("R12 none lost", m_cnt - b, 3);
    chk("R12 order v0", m_data[b], 32'h0000_ABCC);
    chk("R12 order v1", m_data[b+1], 32'h0000_ABCD);
    chk("R12 order v2", m_data[b+2], 32'h0000_ABCE);
  endtask

  task automatic t_disabled;
    logic [31:0] d; int b;
    wr(0, 32'h0000_0000, 4'b0100);
    wr(4, 32'h1);
    b = m_cnt; pulse(4'b0011); idle(5);
    chk("R11 no message when disabled", m_cnt - b, 0);
    rd(5, d); chk("R11 no pending when disabled", d, 0);
    chk("R9 intx follows request", intx_out, 1);
  endtask

  task automatic t_reset_mid;
    logic [31:0] d;
    wr(0, 32'h0021_0000, 4'b0100);
    wr(4, 32'h1); pulse(4'b0001);
    @(negedge clk); rst_n = 1'b0;
    idle(2); rst_n = 1'b1;
    rd(0, d); chk("R10 ctrl", d, 32'h0184_0000);
    rd(2, d); chk("R10 addr hi", d, 0);
    rd(3, d); chk("R10 data", d, 0);
    rd(4, d); chk("R10 mask", d, 0);
    rd(5, d); chk("R10 pending", d, 0);
  endtask

  initial begin
    idle(3); rst_n = 1'b1;
    t_reset_state();
    t_ctrl();
    t_regs();
    t_message();
    t_mask_replay();
    t_stall();
    t_disabled();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule